// File: doc/BRIEF.md
# Two-Port Parallel I/O with Direction Control

The block provides two 8-bit general-purpose parallel ports, named A and B. Each port holds an output latch and a direction mask. A direction bit of 1 turns the matching pin into an output that carries the latched bit. A direction bit of 0 makes the pin an input. An input pin presents a logic 1 on its effective output, as if a pull-up held it. A host reaches the four registers through a small window: a chip select, a write/read strobe, a 2-bit register index and an 8-bit data bus.

The two ports read back in different ways.
- **Port A** returns the wired-AND of the level the block drives and the level the outside world presents. Either side can pull a bit low.
- **Port B** returns the latched bit on output pins and the external bit on input pins.

Writing the port A latch raises a one-cycle strobe. Serial devices hung on port A use it to sample the new pin levels.

Top module: `pio_dual_port`

## Requirements
- R1: While reset is asserted, and after it is released, both latches and both direction masks hold 0x00. Every pin output then reads 0xFF.
- R2: A write takes place on the rising clock edge when `cs`=1 and `we`=1. The register index `addr` selects the target: 0 is the port A latch, 1 is the port A direction mask, 2 is the port B latch and 3 is the port B direction mask.
- R3: A read of index 1 or 3 returns the stored direction mask unchanged.
- R4: Each effective pin output bit equals the latch bit OR the inverted direction bit. Pin outputs follow the registers combinationally and change right after the write edge.
- R5: A read of index 0 returns (latch_A OR NOT dir_A) AND `ext_a`. A bit reads 0 when the outside drives it low, or when it is an output holding 0.
- R6: A read of index 2 returns (latch_B OR NOT dir_B) AND (`ext_b` OR dir_B). Output bits show the latch, and input bits show `ext_b`.
- R7: A cycle with `cs`=0, or with `we`=0, leaves all four registers unchanged.
- R8: `a_wr_stb` is 1 for exactly the one cycle after each edge that writes index 0, and is 0 at all other times.
- R9: `rdata` is 0x00 unless `cs`=1 and `we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select for register access |
| we | input | 1 | 1 = write, 0 = read (valid while cs=1) |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| ext_a | input | 8 | External levels seen on port A |
| ext_b | input | 8 | External levels seen on port B |
| pin_a | output | 8 | Effective level driven on port A |
| pin_b | output | 8 | Effective level driven on port B |
| a_wr_stb | output | 1 | One-cycle pulse after a port A latch write |

## Verification
The assertions assume that `cs`, `we`, `addr` and `wdata` are steady around the rising edge. They also assume that `cs` is held low while reset is asserted, so no write is mistaken for one made during reset.

The bench changes every input only on the falling edge and keeps `cs` at 0 throughout reset. Its random stimulus covers every index, both strobe values and arbitrary external bytes. Directed cases add all-zero and all-one masks and back-to-back port A writes.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W = 8;
  localparam int unsigned PIO_NREG = 4;
  localparam int unsigned PIO_AW = $clog2(PIO_NREG);

  typedef logic [PIO_W-1:0] pio_byte_t;

  typedef enum logic [PIO_AW-1:0] {
    SEL_LATCH_A = 2'd0,
    SEL_DIR_A   = 2'd1,
    SEL_LATCH_B = 2'd2,
    SEL_DIR_B   = 2'd3
  } pio_sel_e;

  typedef enum logic {
    RB_WIRED_AND,
    RB_OUT_MASKED
  } pio_rb_e;

  // Level presented on a pin: outputs carry the latch, inputs idle high.
  function automatic pio_byte_t drive_lvl(pio_byte_t latch, pio_byte_t dir);
    return latch | ~dir;
  endfunction

  // Read-back where either side may pull a bit low.
  function automatic pio_byte_t rb_wand(pio_byte_t latch, pio_byte_t dir, pio_byte_t ext);
    return drive_lvl(latch, dir) & ext;
  endfunction

  // Read-back where output bits override the external level.
  function automatic pio_byte_t rb_masked(pio_byte_t latch, pio_byte_t dir, pio_byte_t ext);
    return drive_lvl(latch, dir) & (ext | dir);
  endfunction
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIO_AW-1:0] wr_idx,
  input  pio_byte_t         wr_val,
  output pio_byte_t         latch_a,
  output pio_byte_t         dir_a,
  output pio_byte_t         latch_b,
  output pio_byte_t         dir_b,
  output logic              a_stb
);
  pio_byte_t regs [PIO_NREG];
  logic      hit_latch_a;

  for (genvar gi = 0; gi < PIO_NREG; gi++) begin : g_reg
    logic sel_hit;
    assign sel_hit = wr_en && (wr_idx == PIO_AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regs[gi] <= '0;
      else if (sel_hit) regs[gi] <= wr_val;
    end
  end

  assign hit_latch_a = wr_en && (wr_idx == SEL_LATCH_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_stb <= 1'b0;
    else        a_stb <= hit_latch_a;
  end

  assign latch_a = regs[SEL_LATCH_A];
  assign dir_a   = regs[SEL_DIR_A];
  assign latch_b = regs[SEL_LATCH_B];
  assign dir_b   = regs[SEL_DIR_B];

  // R2
  dir_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == SEL_DIR_A) |=> (dir_a == $past(wr_val)));
  // R7
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(latch_a) && $stable(dir_a) && $stable(latch_b) && $stable(dir_b)));
  // R8
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_stb |-> $past(wr_en && wr_idx == SEL_LATCH_A));
  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_stb && !hit_latch_a) |=> !a_stb);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter pio_rb_e RB_MODE = RB_WIRED_AND
) (
  input  logic      rst_n,
  input  pio_byte_t latch,
  input  pio_byte_t dir,
  input  pio_byte_t ext,
  output pio_byte_t pin,
  output pio_byte_t rb
);
  assign pin = drive_lvl(latch, dir);

  if (RB_MODE == RB_WIRED_AND) begin : g_wand
    assign rb = rb_wand(latch, dir, ext);
    always_comb begin
      if (rst_n) begin
        // R5
        wand_low_cause_chk: assert ((~rb & ext & ~(dir & ~latch)) == '0);
      end
    end
  end else begin : g_masked
    assign rb = rb_masked(latch, dir, ext);
    always_comb begin
      if (rst_n) begin
        // R6
        masked_in_bits_chk: assert (((rb ^ ext) & ~dir) == '0);
      end
    end
  end

  always_comb begin
    if (rst_n) begin
      // R4
      pin_idle_high_chk: assert ((~dir & ~pin) == '0);
    end
  end
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [PIO_AW-1:0] addr,
  input  logic [PIO_W-1:0]  wdata,
  output logic [PIO_W-1:0]  rdata,
  input  logic [PIO_W-1:0]  ext_a,
  input  logic [PIO_W-1:0]  ext_b,
  output logic [PIO_W-1:0]  pin_a,
  output logic [PIO_W-1:0]  pin_b,
  output logic              a_wr_stb
);
  pio_byte_t latch_a, dir_a, latch_b, dir_b;
  pio_byte_t rb_a, rb_b;
  logic      wr_en, rd_en;

  assign wr_en = cs && we;
  assign rd_en = cs && !we;

  pio_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (addr),
    .wr_val  (wdata),
    .latch_a (latch_a),
    .dir_a   (dir_a),
    .latch_b (latch_b),
    .dir_b   (dir_b),
    .a_stb   (a_wr_stb)
  );

  pio_port #(.RB_MODE(RB_WIRED_AND)) u_port_a (
    .rst_n (rst_n),
    .latch (latch_a),
    .dir   (dir_a),
    .ext   (ext_a),
    .pin   (pin_a),
    .rb    (rb_a)
  );

  pio_port #(.RB_MODE(RB_OUT_MASKED)) u_port_b (
    .rst_n (rst_n),
    .latch (latch_b),
    .dir   (dir_b),
    .ext   (ext_b),
    .pin   (pin_b),
    .rb    (rb_b)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        SEL_LATCH_A: rdata = rb_a;
        SEL_DIR_A:   rdata = dir_a;
        SEL_LATCH_B: rdata = rb_b;
        SEL_DIR_B:   rdata = dir_b;
        default:     rdata = '0;
      endcase
    end
  end

  // R8
  stb_pin_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_stb |-> (pin_a == ($past(wdata) | ~dir_a)));
  // R3
  dir_b_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_DIR_B) |-> (rdata == u_regs.dir_b));
endmodule

// File: tb/pio_dual_port_tb_top.sv
`timescale 1ns/1ps
module pio_dual_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, ext_a = 8'hFF, ext_b = 8'hFF;
  logic [7:0] rdata, pin_a, pin_b;
  logic       a_wr_stb;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_la = 0, m_da = 0, m_lb = 0, m_db = 0;

  always #2.5 clk = ~clk;

  pio_dual_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_a(ext_a), .ext_b(ext_b),
    .pin_a(pin_a), .pin_b(pin_b), .a_wr_stb(a_wr_stb)
  );

  function automatic logic [7:0] e_pin(logic [7:0] l, logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[i] ? l[i] : 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] e_rd_a(logic [7:0] l, logic [7:0] d, logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = !(!x[i] || (d[i] && !l[i]));
    return r;
  endfunction

  function automatic logic [7:0] e_rd_b(logic [7:0] l, logic [7:0] d, logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[i] ? l[i] : x[i];
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic expect_rd(logic c, logic w, logic [1:0] a);
    if (!(c && !w))     chk("R9", rdata, 8'h00);
    else if (a == 2'd0) chk("R5", rdata, e_rd_a(m_la, m_da, ext_a));
    else if (a == 2'd1) chk("R3", rdata, m_da);
    else if (a == 2'd2) chk("R6", rdata, e_rd_b(m_lb, m_db, ext_b));
    else                chk("R3", rdata, m_db);
  endtask

  // One bus cycle: drive at falling edge, check read data, then check the effect after the edge.
  task automatic op(logic c, logic w, logic [1:0] a, logic [7:0] d, logic [7:0] xa, logic [7:0] xb);
    bit wr;
    @(negedge clk);
    cs = c; we = w; addr = a; wdata = d; ext_a = xa; ext_b = xb;
    #0.5;
    expect_rd(c, w, a);
    wr = c && w;
    @(posedge clk);
    #1;
    if (wr) begin
      case (a)
        2'd0: m_la = d;
        2'd1: m_da = d;
        2'd2: m_lb = d;
        default: m_db = d;
      endcase
    end
    chk("R4", pin_a, e_pin(m_la, m_da));
    chk("R4", pin_b, e_pin(m_lb, m_db));
    chk("R8", {7'd0, a_wr_stb}, {7'd0, wr && a == 2'd0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: during reset
    chk("R1", pin_a, 8'hFF);
    chk("R1", pin_b, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: after reset
    op(1, 0, 2'd1, 8'h00, 8'hFF, 8'hFF);
    op(1, 0, 2'd0, 8'h00, 8'hFF, 8'h3C);
    chk("R1", rdata, 8'hFF);
    // R2 R3: every index gets its own value
    op(1, 1, 2'd0, 8'hA5, 8'hFF, 8'hFF);
    op(1, 1, 2'd1, 8'h0F, 8'hFF, 8'hFF);
    op(1, 1, 2'd2, 8'h5A, 8'hFF, 8'hFF);
    op(1, 1, 2'd3, 8'hF0, 8'hFF, 8'hFF);
    op(1, 0, 2'd1, 8'h00, 8'hFF, 8'hFF);
    op(1, 0, 2'd3, 8'h00, 8'hFF, 8'hFF);
    // R5: outside pulls low on an input bit, latch 0 on an output bit
    op(1, 0, 2'd0, 8'h00, 8'h7F, 8'hFF);
    // R6: external bits show only on input bits
    op(1, 0, 2'd2, 8'h00, 8'hFF, 8'h00);
    // R7: writes blocked by cs=0 and by we=0
    op(0, 1, 2'd1, 8'h33, 8'hFF, 8'hFF);
    op(1, 0, 2'd1, 8'h33, 8'hFF, 8'hFF);
    // R8: back-to-back port A latch writes
    op(1, 1, 2'd0, 8'h00, 8'hFF, 8'hFF);
    op(1, 1, 2'd0, 8'hFF, 8'hFF, 8'hFF);
    op(1, 0, 2'd0, 8'h00, 8'hFF, 8'hFF);
    // All-output and all-input masks
    op(1, 1, 2'd1, 8'hFF, 8'hFF, 8'hFF);
    op(1, 1, 2'd3, 8'h00, 8'hFF, 8'hFF);
    op(1, 0, 2'd0, 8'h00, 8'h00, 8'h00);
    op(1, 0, 2'd2, 8'h00, 8'h00, 8'h96);
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      op(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
         8'($urandom), 8'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule